// File: doc/BRIEF.md
# UART Receiver Idle Time-Out Detector

This block sits beside a UART receiver and reports the end of a variable-length frame. After a character arrives, it counts bit periods while the receive line stays quiet. When the programmed number of bit periods passes with no new character, it sets a sticky time-out flag. The flag drives an interrupt request through an enable input.

The receiver's baud generator supplies a one-cycle strobe for each bit period. The deserialiser supplies a one-cycle pulse for each completed character. Software writes two commands as single-cycle pulses:
- An arm-and-wait command clears the flag and suspends counting until the next character.
- A reload command clears the flag and starts a fresh countdown at once.

A programmed value of zero turns the detector off.

Top module: `rx_idle_timeout`

## Requirements
- R1: While `to_value` is 0 the detector is off. The flag is cleared on the next edge and stays 0 whatever strobes, characters or commands arrive. Being off takes priority over every command.
- R2: After a character pulse with a non-zero `to_value` of N, the flag rises on the clock edge that samples the N-th following `bit_tick`.
- R3: The countdown advances only on cycles with `bit_tick` high. Any number of system clocks without a strobe leave the count unchanged.
- R4: A character pulse during a countdown reloads the full value, so N further strobes are needed before the flag rises.
- R5: When `char_rcvd` and `bit_tick` are high in the same cycle, the reload wins and that strobe is not counted.
- R6: `cmd_arm_wait` clears the flag on the next edge. Strobes are then ignored until a character pulse arrives.
- R7: `cmd_reload` clears the flag, loads `to_value` and starts counting at once, with no character needed.
- R8: The flag is set once per countdown and then held. The count stops at zero and does not wrap, and later strobes and character pulses leave the flag set. Only a command or a zero value clears it.
- R9: A change of `to_value` takes effect only at the next load (a character or `cmd_reload`). A countdown in progress keeps the value it loaded.
- R10: `irq` is high exactly when the flag is set and `irq_en` is high.
- R11: After reset the flag is 0 and the detector waits for a character. Strobes before the first character do not set the flag.
- R12: Priority among same-cycle inputs, from highest to lowest: `cmd_reload`, then `cmd_arm_wait`, then `char_rcvd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per receiver bit period |
| char_rcvd | input | 1 | One-cycle pulse per received character |
| to_value | input | CNT_W | Programmed time-out length in bit periods; 0 turns the detector off |
| cmd_arm_wait | input | 1 | Clear the flag and suspend counting until the next character |
| cmd_reload | input | 1 | Clear the flag, reload and count at once |
| irq_en | input | 1 | Interrupt enable |
| timeout_flag | output | 1 | Sticky time-out status |
| irq | output | 1 | Interrupt request |

## Verification
The flag is registered, so every input's effect on it (strobe, character, command or a zero value) is visible one clock edge after the cycle that presents it. `irq` follows the flag and the enable combinationally in the same cycle. The bench drives each stimulus for exactly one cycle and samples 1 ns after the capturing rising edge, well away from the next edge. Each expected flag value is therefore the result of the single edge just taken. The expected values come from counting strobes against the loaded value, not from the design.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    typedef enum logic [1:0] {
        RX_WAIT = 2'd0,
        RX_RUN  = 2'd1,
        RX_DONE = 2'd2
    } rxto_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic tick;
        logic chr;
        logic arm;
        logic reload;
    } rxto_evt_t;

    typedef struct packed {
        rxto_state_e nxt_state;
        cnt_op_e     op;
        logic        set_flag;
        logic        clr_flag;
    } rxto_dec_t;

    function automatic rxto_dec_t rxto_decide(
        input rxto_evt_t   evt,
        input rxto_state_e cur,
        input logic        off,
        input logic        at_one
    );
        rxto_dec_t d;
        d.nxt_state = cur;
        d.op        = CNT_HOLD;
        d.set_flag  = 1'b0;
        d.clr_flag  = 1'b0;
        if (off) begin
            d.nxt_state = RX_WAIT;
            d.clr_flag  = 1'b1;
        end else if (evt.reload) begin
            d.nxt_state = RX_RUN;
            d.op        = CNT_LOAD;
            d.clr_flag  = 1'b1;
        end else if (evt.arm) begin
            d.nxt_state = RX_WAIT;
            d.clr_flag  = 1'b1;
        end else if (evt.chr) begin
            d.nxt_state = RX_RUN;
            d.op        = CNT_LOAD;
        end else if (cur == RX_RUN && evt.tick) begin
            d.op = CNT_DEC;
            if (at_one) begin
                d.set_flag  = 1'b1;
                d.nxt_state = RX_DONE;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/rxto_counter.sv
module rxto_counter
    import rxto_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_op_e      op,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         at_one
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                CNT_LOAD: cnt <= load_val;
                CNT_DEC:  cnt <= (cnt == '0) ? cnt : cnt - ONE;
                default:  cnt <= cnt;
            endcase
        end
    end

    assign at_one = (cnt == ONE);
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
    import rxto_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rxto_evt_t   evt,
    input  logic        off,
    input  logic        at_one,
    output cnt_op_e     op,
    output logic        flag
);
    rxto_state_e state_q;
    rxto_dec_t   dec;

    always_comb begin
        dec = rxto_decide(evt, state_q, off, at_one);
    end

    assign op = dec.op;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_WAIT;
            flag    <= 1'b0;
        end else begin
            state_q <= dec.nxt_state;
            if (dec.clr_flag)
                flag <= 1'b0;
            else if (dec.set_flag)
                flag <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             char_rcvd,
    input  logic [CNT_W-1:0] to_value,
    input  logic             cmd_arm_wait,
    input  logic             cmd_reload,
    input  logic             irq_en,
    output logic             timeout_flag,
    output logic             irq
);
    rxto_evt_t        evt;
    cnt_op_e          op;
    logic [CNT_W-1:0] cnt_q;
    logic             at_one;
    logic             off;

    assign evt.tick   = bit_tick;
    assign evt.chr    = char_rcvd;
    assign evt.arm    = cmd_arm_wait;
    assign evt.reload = cmd_reload;
    assign off        = (to_value == '0);

    rxto_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .off    (off),
        .at_one (at_one),
        .op     (op),
        .flag   (timeout_flag)
    );

    rxto_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (to_value),
        .cnt      (cnt_q),
        .at_one   (at_one)
    );

    assign irq = timeout_flag & irq_en;
endmodule

// File: rtl/rxto_checker.sv
module rxto_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_tick,
    input logic             char_rcvd,
    input logic [CNT_W-1:0] to_value,
    input logic             cmd_arm_wait,
    input logic             cmd_reload,
    input logic             irq_en,
    input logic             timeout_flag,
    input logic             irq,
    input logic [CNT_W-1:0] cnt
);
    logic on;
    assign on = (to_value != '0);

    AST_ZERO_KEEPS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !on |=> !timeout_flag); // R1
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> !$rose(timeout_flag)); // R3
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && !char_rcvd && !cmd_reload) |=> $stable(cnt)); // R3
    AST_CHAR_LOADS: assert property (@(posedge clk) disable iff (rst)
        (char_rcvd && on && !cmd_reload && !cmd_arm_wait) |=> cnt == $past(to_value)); // R4
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_arm_wait |=> !timeout_flag); // R6
    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd_reload && on) |=> (!timeout_flag && cnt == $past(to_value))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && on && !cmd_arm_wait && !cmd_reload) |=> timeout_flag); // R8
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && timeout_flag)); // R10
endmodule

bind rx_idle_timeout rxto_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_tick     (bit_tick),
    .char_rcvd    (char_rcvd),
    .to_value     (to_value),
    .cmd_arm_wait (cmd_arm_wait),
    .cmd_reload   (cmd_reload),
    .irq_en       (irq_en),
    .timeout_flag (timeout_flag),
    .irq          (irq),
    .cnt          (cnt_q)
);

// File: tb/sim_rx_idle_timeout.sv
`timescale 1ns/1ps
module sim_rx_idle_timeout;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic       tick;
        logic       chr;
        logic       arm;
        logic       rld;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 38;
    // to_value = 3, irq_en = 1 throughout the table
    localparam vec_t VEC [NV] = '{
        '{0,1,0,0,0,4'd2},  // char loads 3
        '{1,0,0,0,0,4'd2},
        '{0,0,0,0,0,4'd3},  // R3 idle clock, no count
        '{1,0,0,0,0,4'd2},
        '{1,0,0,0,1,4'd2},  // R2 third tick sets
        '{1,0,0,0,1,4'd8},  // R8 held, no wrap
        '{0,1,0,0,1,4'd8},  // R8 char keeps flag
        '{1,0,0,0,1,4'd8},
        '{1,0,0,0,1,4'd8},
        '{1,0,0,0,1,4'd8},
        '{0,0,1,0,0,4'd6},  // R6 arm clears
        '{1,0,0,0,0,4'd6},
        '{1,0,0,0,0,4'd6},
        '{1,0,0,0,0,4'd6},
        '{1,0,0,0,0,4'd6},  // R6 suspended
        '{0,0,0,1,0,4'd7},  // R7 reload starts
        '{1,0,0,0,0,4'd7},
        '{1,0,0,0,0,4'd7},
        '{1,0,0,0,1,4'd7},
        '{0,0,1,0,0,4'd6},
        '{1,1,0,0,0,4'd5},  // R5 char+tick: reload wins
        '{1,0,0,0,0,4'd5},
        '{1,0,0,0,0,4'd5},
        '{1,0,0,0,1,4'd5},
        '{0,0,1,0,0,4'd6},
        '{0,1,0,0,0,4'd4},  // R4
        '{1,0,0,0,0,4'd4},
        '{1,0,0,0,0,4'd4},
        '{0,1,0,0,0,4'd4},  // R4 reload mid-count
        '{1,0,0,0,0,4'd4},
        '{1,0,0,0,0,4'd4},
        '{1,0,0,0,1,4'd4},
        '{0,0,1,1,0,4'd12}, // R12 reload beats arm
        '{1,0,0,0,0,4'd12},
        '{1,0,0,0,0,4'd12},
        '{1,0,0,0,1,4'd12},
        '{0,1,1,0,0,4'd12}, // R12 arm beats char
        '{1,0,0,0,0,4'd12}
    };

    logic clk = 1'b0;
    logic rst;
    logic bit_tick, char_rcvd, cmd_arm_wait, cmd_reload, irq_en;
    logic [CNT_W-1:0] to_value;
    logic timeout_flag, irq;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rx_idle_timeout #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
        .to_value(to_value), .cmd_arm_wait(cmd_arm_wait), .cmd_reload(cmd_reload),
        .irq_en(irq_en), .timeout_flag(timeout_flag), .irq(irq)
    );

    task automatic cyc(input logic t, input logic c, input logic a, input logic r);
        bit_tick = t; char_rcvd = c; cmd_arm_wait = a; cmd_reload = r;
        @(posedge clk);
        #1;
        bit_tick = 0; char_rcvd = 0; cmd_arm_wait = 0; cmd_reload = 0;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; bit_tick = 0; char_rcvd = 0; cmd_arm_wait = 0; cmd_reload = 0;
        irq_en = 1; to_value = 16'd3;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R11", timeout_flag, 1'b0);
        chk("R11", irq, 1'b0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
        chk("R11", timeout_flag, 1'b0);   // R11 no count before first char

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].tick, VEC[i].chr, VEC[i].arm, VEC[i].rld);
            checks++;
            if (timeout_flag !== VEC[i].exp || irq !== VEC[i].exp) begin
                errors++;
                $display("FAIL R%0d: vec %0d got flag %b irq %b expected %b",
                         VEC[i].req, i, timeout_flag, irq, VEC[i].exp);
            end
        end

        // R3: many idle clocks in a run do not count
        cyc(0, 0, 0, 1);
        repeat (20) cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        chk("R3", timeout_flag, 1'b0);
        cyc(1, 0, 0, 0);
        chk("R3", timeout_flag, 1'b1);

        // R10: gating by enable
        irq_en = 0; #1;
        chk("R10", irq, 1'b0);
        irq_en = 1; #1;
        chk("R10", irq, 1'b1);

        // R1: zero value clears and disables
        to_value = '0;
        cyc(0, 0, 0, 0);
        chk("R1", timeout_flag, 1'b0);
        cyc(0, 0, 0, 1);
        cyc(0, 1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
        chk("R1", timeout_flag, 1'b0);
        chk("R1", irq, 1'b0);

        // R9: new value applies at next load only
        to_value = 16'd3;
        cyc(0, 0, 0, 1);
        cyc(1, 0, 0, 0);
        to_value = 16'd10;
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        chk("R9", timeout_flag, 1'b1);
        cyc(0, 0, 1, 0);
        cyc(0, 1, 0, 0);
        for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0);
        chk("R9", timeout_flag, 1'b0);
        cyc(1, 0, 0, 0);
        chk("R9", timeout_flag, 1'b1);

        // R2: wide value counts exactly N strobes
        to_value = 16'd300;
        cyc(0, 0, 1, 0);
        cyc(0, 1, 0, 0);
        for (int i = 0; i < 299; i++) begin
            cyc(1, 0, 0, 0);
            cyc(0, 0, 0, 0);
        end
        chk("R2", timeout_flag, 1'b0);
        cyc(1, 0, 0, 0);
        chk("R2", timeout_flag, 1'b1);

        // R11: reset clears a set flag
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        chk("R11", timeout_flag, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule